// File: doc/BRIEF.md
# Subroutine Return-Address Stack with Boundary Trap

This block keeps return addresses for a small processor. Each subroutine call or interrupt entry pushes the current program address, and each return pops one. A pointer register, called the depth pointer here, selects the top entry. Slot 0 is reserved for the interrupt handler's start address. Interrupt entry always takes its target from slot 0, whatever the pointer holds.

When a call brings the stack near full, or a return finds it empty, the block raises a sticky boundary flag. Software can then move half of the entries to memory and carry on, so nesting depth is not limited by the hardware. A side port lets software write the pointer or any slot and read any slot. After such a write, a two-state machine holds `settled_o` low for a fixed number of clocks. The machine has a state `ST_RUN` and a state `ST_SETTLE`. Any software write moves it to `ST_SETTLE`, and a later write restarts the count. When the count runs out it returns to `ST_RUN`.

The pushed return address is the program address as presented on `pc_i`. Any adjustment of that address is left to the caller.

Top module: `exit_stack`

## Requirements
- R1: After reset the pointer is 0, every slot reads 0, the boundary flag and the interrupt enable are 0, `target_vld_o` is 0 and `settled_o` is 1.
- R2: A call adds 1 to the pointer and stores `pc_i` in the slot at the new pointer value. A call produces no target.
- R3: A return with a nonzero pointer delivers the slot at the current pointer on `target_o`, with `target_vld_o` high, one clock after the request. It then subtracts 1 from the pointer.
- R4: Interrupt entry stores `pc_i` at pointer+1 and advances the pointer. It delivers slot 0 as the target one clock later and clears the interrupt enable.
- R5: The boundary flag sets when a call makes the pointer equal to DEPTH-2 (14). An interrupt entry that reaches 14 leaves the flag unchanged.
- R6: A return with the pointer at 0 sets the boundary flag, delivers slot 0 as the target and leaves the pointer at 0.
- R7: A call or interrupt entry with the pointer at 15 wraps the pointer to 0 and stores `pc_i` in slot 0.
- R8: A software write of the pointer (`sw_wr_ptr_i`, new value on `sw_idx_i`) or of a slot (`sw_wr_slot_i`) cancels a call, return or interrupt entry requested in the same cycle. The cancelled request moves no pointer, stores nothing and produces no target.
- R9: After any software write, `settled_o` stays low for exactly 5 clocks and is then high again.
- R10: When several requests arrive together, interrupt entry wins over call, and call wins over return.
- R11: The boundary flag stays set until `sw_flag_clr_i` is pulsed. The interrupt enable is set by `sw_ie_set_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| call_i | input | 1 | Subroutine call request |
| ret_i | input | 1 | Return request |
| irq_i | input | 1 | Interrupt entry request |
| pc_i | input | 16 | Address to push |
| sw_wr_ptr_i | input | 1 | Software writes the pointer from `sw_idx_i` |
| sw_wr_slot_i | input | 1 | Software writes slot `sw_idx_i` with `sw_data_i` |
| sw_idx_i | input | 4 | Slot select for the side port, and the new pointer value |
| sw_data_i | input | 16 | Slot write data |
| sw_ie_set_i | input | 1 | Set the interrupt enable |
| sw_flag_clr_i | input | 1 | Clear the boundary flag |
| target_o | output | 16 | Return or handler address |
| target_vld_o | output | 1 | `target_o` valid for this cycle |
| bnd_irq_o | output | 1 | Boundary flag (interrupt request) |
| ie_o | output | 1 | System interrupt enable |
| ptr_o | output | 4 | Current pointer |
| slot_data_o | output | 16 | Contents of slot `sw_idx_i` |
| settled_o | output | 1 | Stack reads are valid |

## Verification
The main push/pop path is tried with three patterns. A nested call/return chain tells apart LIFO order from a plain register. Interrupt entry tells apart slot-0 vectoring from a normal pop. A return at an empty stack tells apart the trap path from a pointer underflow. Boundary patterns start the pointer at 13 and at 15 through the side port. These show that the flag depends on which request reached 14, and how the wrap overwrites slot 0. Requests that collide with each other and with software writes check the priority rules, and the readback checks that nothing leaked through.

// File: rtl/exs_pkg.sv
package exs_pkg;
    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_CALL = 2'd1,
        OP_RET  = 2'd2,
        OP_IRQ  = 2'd3
    } exs_op_e;

    typedef enum logic {
        ST_RUN    = 1'b0,
        ST_SETTLE = 1'b1
    } exs_settle_e;
endpackage

// File: rtl/exs_store.sv
module exs_store #(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 16,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [PTR_W-1:0]  waddr,
    input  logic [ADDR_W-1:0] wdata,
    input  logic [PTR_W-1:0]  raddr_a,
    input  logic [PTR_W-1:0]  raddr_b,
    output logic [ADDR_W-1:0] rdata_a,
    output logic [ADDR_W-1:0] rdata_b,
    output logic [ADDR_W-1:0] rdata_vec
);
    logic [ADDR_W-1:0] slot_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q[g] <= '0;
            end else if (we && waddr == PTR_W'(g)) begin
                slot_q[g] <= wdata;
            end
        end
    end

    assign rdata_a   = slot_q[raddr_a];
    assign rdata_b   = slot_q[raddr_b];
    assign rdata_vec = slot_q[0];
endmodule

// File: rtl/exs_settle.sv
module exs_settle
    import exs_pkg::*;
#(
    parameter int SETTLE_CYC = 5,
    localparam int CNT_W = $clog2(SETTLE_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic touch,
    output logic settled
);
    exs_settle_e st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            ST_RUN: begin
                if (touch) begin
                    st_d  = ST_SETTLE;
                    cnt_d = CNT_W'(SETTLE_CYC - 1);
                end
            end
            ST_SETTLE: begin
                if (touch) begin
                    cnt_d = CNT_W'(SETTLE_CYC - 1);
                end else if (cnt_q == '0) begin
                    st_d = ST_RUN;
                end else begin
                    cnt_d = cnt_q - CNT_W'(1);
                end
            end
            default: st_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_RUN;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        settled = (st_q == ST_RUN);
    end

    // R9
    touch_unsettles_chk: assert property (@(posedge clk) disable iff (!rst_n)
        touch |=> !settled);
endmodule

// File: rtl/exs_ptr_ctrl.sv
module exs_ptr_ctrl
    import exs_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             call_req,
    input  logic             ret_req,
    input  logic             irq_req,
    input  logic             sw_wr_ptr,
    input  logic             sw_wr_slot,
    input  logic [PTR_W-1:0] sw_ptr_val,
    input  logic             flag_clr,
    input  logic             ie_set,
    output exs_op_e          op,
    output logic [PTR_W-1:0] ptr,
    output logic [PTR_W-1:0] ptr_next_slot,
    output logic             flag,
    output logic             ie
);
    localparam logic [PTR_W-1:0] ONE       = PTR_W'(1);
    localparam logic [PTR_W-1:0] FULL_MARK = PTR_W'(DEPTH - 2);

    logic [PTR_W-1:0] ptr_q, ptr_d;
    logic             flag_q, flag_d, ie_q, ie_d, flag_set;

    always_comb begin
        if (sw_wr_ptr || sw_wr_slot) op = OP_NONE;
        else if (irq_req)            op = OP_IRQ;
        else if (call_req)           op = OP_CALL;
        else if (ret_req)            op = OP_RET;
        else                         op = OP_NONE;
    end

    assign ptr_next_slot = ptr_q + ONE;

    always_comb begin
        ptr_d    = ptr_q;
        flag_set = 1'b0;
        unique case (op)
            OP_CALL: begin
                ptr_d    = ptr_next_slot;
                flag_set = (ptr_next_slot == FULL_MARK);
            end
            OP_IRQ: begin
                ptr_d = ptr_next_slot;
            end
            OP_RET: begin
                if (ptr_q == '0) flag_set = 1'b1;
                else             ptr_d    = ptr_q - ONE;
            end
            default: ;
        endcase
        if (sw_wr_ptr) ptr_d = sw_ptr_val;
    end

    always_comb begin
        flag_d = flag_set | (flag_q & ~flag_clr);
        if (op == OP_IRQ) ie_d = 1'b0;
        else if (ie_set)  ie_d = 1'b1;
        else              ie_d = ie_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q  <= '0;
            flag_q <= 1'b0;
            ie_q   <= 1'b0;
        end else begin
            ptr_q  <= ptr_d;
            flag_q <= flag_d;
            ie_q   <= ie_d;
        end
    end

    assign ptr  = ptr_q;
    assign flag = flag_q;
    assign ie   = ie_q;

    // R2
    call_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (call_req && !irq_req && !sw_wr_ptr && !sw_wr_slot) |=> ptr == $past(ptr) + ONE);
    // R4
    irq_clears_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !sw_wr_ptr && !sw_wr_slot) |=> !ie);
    // R8
    sw_ptr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_wr_ptr |=> ptr == $past(sw_ptr_val));
endmodule

// File: rtl/exit_stack.sv
module exit_stack
    import exs_pkg::*;
#(
    parameter int DEPTH      = 16,
    parameter int ADDR_W     = 16,
    parameter int SETTLE_CYC = 5,
    localparam int PTR_W     = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              call_i,
    input  logic              ret_i,
    input  logic              irq_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic              sw_wr_ptr_i,
    input  logic              sw_wr_slot_i,
    input  logic [PTR_W-1:0]  sw_idx_i,
    input  logic [ADDR_W-1:0] sw_data_i,
    input  logic              sw_ie_set_i,
    input  logic              sw_flag_clr_i,
    output logic [ADDR_W-1:0] target_o,
    output logic              target_vld_o,
    output logic              bnd_irq_o,
    output logic              ie_o,
    output logic [PTR_W-1:0]  ptr_o,
    output logic [ADDR_W-1:0] slot_data_o,
    output logic              settled_o
);
    exs_op_e           op;
    logic [PTR_W-1:0]  ptr, next_slot, waddr;
    logic [ADDR_W-1:0] top_data, vec_data, wdata, tgt_d, tgt_q;
    logic              we, push, vld_d, vld_q, flag, ie;

    exs_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
        .clk(clk), .rst_n(rst_n),
        .call_req(call_i), .ret_req(ret_i), .irq_req(irq_i),
        .sw_wr_ptr(sw_wr_ptr_i), .sw_wr_slot(sw_wr_slot_i),
        .sw_ptr_val(sw_idx_i), .flag_clr(sw_flag_clr_i), .ie_set(sw_ie_set_i),
        .op(op), .ptr(ptr), .ptr_next_slot(next_slot), .flag(flag), .ie(ie)
    );

    assign push  = (op == OP_CALL) || (op == OP_IRQ);
    assign we    = sw_wr_slot_i || push;
    assign waddr = sw_wr_slot_i ? sw_idx_i : next_slot;
    assign wdata = sw_wr_slot_i ? sw_data_i : pc_i;

    exs_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .we(we), .waddr(waddr), .wdata(wdata),
        .raddr_a(ptr), .raddr_b(sw_idx_i),
        .rdata_a(top_data), .rdata_b(slot_data_o), .rdata_vec(vec_data)
    );

    exs_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
        .clk(clk), .rst_n(rst_n),
        .touch(sw_wr_ptr_i || sw_wr_slot_i),
        .settled(settled_o)
    );

    always_comb begin
        tgt_d = top_data;
        vld_d = 1'b0;
        unique case (op)
            OP_IRQ: begin
                tgt_d = vec_data;
                vld_d = 1'b1;
            end
            OP_RET: begin
                tgt_d = (ptr == '0) ? vec_data : top_data;
                vld_d = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_q <= '0;
            vld_q <= 1'b0;
        end else begin
            tgt_q <= tgt_d;
            vld_q <= vld_d;
        end
    end

    assign target_o     = tgt_q;
    assign target_vld_o = vld_q;
    assign bnd_irq_o    = flag;
    assign ie_o         = ie;
    assign ptr_o        = ptr;

    // R3
    target_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(target_vld_o) |-> $past(ret_i || irq_i));
    // R6
    empty_return_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_i && !call_i && !irq_i && !sw_wr_ptr_i && !sw_wr_slot_i && ptr_o == '0)
        |=> (bnd_irq_o && ptr_o == '0 && target_vld_o));
    // R8
    sw_blocks_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_wr_slot_i || sw_wr_ptr_i) |=> !target_vld_o);
endmodule

// File: tb/exit_stack_bench.sv
module exit_stack_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        call_i = 0, ret_i = 0, irq_i = 0;
    logic [15:0] pc_i = '0;
    logic        sw_wr_ptr_i = 0, sw_wr_slot_i = 0, sw_ie_set_i = 0, sw_flag_clr_i = 0;
    logic [3:0]  sw_idx_i = '0;
    logic [15:0] sw_data_i = '0;
    logic [15:0] target_o, slot_data_o;
    logic        target_vld_o, bnd_irq_o, ie_o, settled_o;
    logic [3:0]  ptr_o;

    int n_chk = 0;
    int n_fail = 0;
    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    exit_stack u_exit_stack (.*);

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops expected targets as the design produces them
    always @(negedge clk) begin
        if (rst_n && target_vld_o) begin
            n_chk++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R8 unexpected target actual=%h expected=none", target_o);
            end else begin
                automatic logic [15:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                if (target_o !== e) begin
                    n_fail++;
                    $display("FAIL %s target actual=%h expected=%h", t, target_o, e);
                end
            end
        end
    end

    // driver: one request cycle, expected target pushed to the scoreboard
    task automatic req(input logic c, input logic r, input logic i, input logic [15:0] pc,
                       input bit expect_t, input logic [15:0] exp_t, input string tag);
        call_i = c; ret_i = r; irq_i = i; pc_i = pc;
        if (expect_t) begin exp_q.push_back(exp_t); tag_q.push_back(tag); end
        @(negedge clk);
        call_i = 0; ret_i = 0; irq_i = 0;
    endtask

    task automatic sw_slot(input logic [3:0] idx, input logic [15:0] d);
        sw_wr_slot_i = 1; sw_idx_i = idx; sw_data_i = d;
        @(negedge clk);
        sw_wr_slot_i = 0;
    endtask

    task automatic sw_ptr(input logic [3:0] v);
        sw_wr_ptr_i = 1; sw_idx_i = v;
        @(negedge clk);
        sw_wr_ptr_i = 0;
    endtask

    task automatic rd_slot(input logic [3:0] idx, output logic [15:0] d);
        sw_idx_i = idx;
        #1 d = slot_data_o;
    endtask

    task automatic pulse_clr();
        sw_flag_clr_i = 1; @(negedge clk); sw_flag_clr_i = 0;
    endtask

    initial begin
        logic [15:0] d;
        int cnt;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 ptr", 16'(ptr_o), 16'h0);
        chk("R1 flag", 16'(bnd_irq_o), 16'h0);
        chk("R1 ie", 16'(ie_o), 16'h0);
        chk("R1 vld", 16'(target_vld_o), 16'h0);
        chk("R1 settled", 16'(settled_o), 16'h1);
        rd_slot(4'd7, d); chk("R1 slot", d, 16'h0);

        // handler vector, settle window R9
        sw_slot(4'd0, 16'hA000);
        cnt = 0;
        while (!settled_o && cnt < 10) begin cnt++; @(negedge clk); end
        chk("R9 settle cycles", 16'(cnt), 16'd5);
        sw_ie_set_i = 1; @(negedge clk); sw_ie_set_i = 0;
        chk("R11 ie set", 16'(ie_o), 16'h1);

        // R2 calls, R3 returns
        req(1, 0, 0, 16'h0100, 0, '0, "");
        chk("R2 ptr", 16'(ptr_o), 16'h1);
        rd_slot(4'd1, d); chk("R2 stored", d, 16'h0100);
        req(1, 0, 0, 16'h0200, 0, '0, "");
        chk("R2 ptr", 16'(ptr_o), 16'h2);
        req(0, 1, 0, '0, 1, 16'h0200, "R3");
        chk("R3 ptr", 16'(ptr_o), 16'h1);
        req(0, 1, 0, '0, 1, 16'h0100, "R3");
        chk("R3 ptr", 16'(ptr_o), 16'h0);

        // R6 empty return
        req(0, 1, 0, '0, 1, 16'hA000, "R6");
        chk("R6 flag", 16'(bnd_irq_o), 16'h1);
        chk("R6 ptr", 16'(ptr_o), 16'h0);
        repeat (2) @(negedge clk);
        chk("R11 flag sticky", 16'(bnd_irq_o), 16'h1);
        pulse_clr();
        chk("R11 flag clear", 16'(bnd_irq_o), 16'h0);

        // R4 interrupt entry
        req(0, 0, 1, 16'h0300, 1, 16'hA000, "R4");
        chk("R4 ptr", 16'(ptr_o), 16'h1);
        chk("R4 ie", 16'(ie_o), 16'h0);
        rd_slot(4'd1, d); chk("R4 stored", d, 16'h0300);

        // R5 boundary asymmetry
        sw_ptr(4'd13);
        req(0, 0, 1, 16'h0D00, 1, 16'hA000, "R4");
        chk("R5 ptr irq", 16'(ptr_o), 16'd14);
        chk("R5 irq no flag", 16'(bnd_irq_o), 16'h0);
        sw_ptr(4'd13);
        req(1, 0, 0, 16'h0E00, 0, '0, "");
        chk("R5 ptr call", 16'(ptr_o), 16'd14);
        chk("R5 call flag", 16'(bnd_irq_o), 16'h1);
        pulse_clr();

        // R7 wrap
        sw_ptr(4'd15);
        req(1, 0, 0, 16'h0BAD, 0, '0, "");
        chk("R7 ptr", 16'(ptr_o), 16'h0);
        rd_slot(4'd0, d); chk("R7 slot0", d, 16'h0BAD);
        sw_slot(4'd0, 16'hA000);

        // R8 software write wins
        sw_ptr(4'd4);
        rd_slot(4'd5, d);
        sw_wr_ptr_i = 1; sw_idx_i = 4'd5; call_i = 1; pc_i = 16'h5555;
        @(negedge clk);
        sw_wr_ptr_i = 0; call_i = 0;
        chk("R8 ptr", 16'(ptr_o), 16'd5);
        rd_slot(4'd6, d); chk("R8 no push", d, 16'h0);
        sw_wr_slot_i = 1; sw_idx_i = 4'd9; sw_data_i = 16'h9999; ret_i = 1;
        @(negedge clk);
        sw_wr_slot_i = 0; ret_i = 0;
        chk("R8 ptr kept", 16'(ptr_o), 16'd5);
        rd_slot(4'd9, d); chk("R8 slot write", d, 16'h9999);

        // R10 priority
        req(1, 1, 0, 16'h6666, 0, '0, "");
        chk("R10 call over ret", 16'(ptr_o), 16'd6);
        rd_slot(4'd6, d); chk("R10 stored", d, 16'h6666);
        req(1, 1, 1, 16'h7777, 1, 16'hA000, "R10");
        chk("R10 irq ie", 16'(ie_o), 16'h0);
        chk("R10 irq ptr", 16'(ptr_o), 16'd7);

        repeat (3) @(negedge clk);
        chk("R3 scoreboard drained", 16'(exp_q.size()), 16'h0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule